// File: doc/BRIEF.md
# Selectable Dual-Modulus Frequency Prescaler

This block is a synchronous divider driven by a fast input clock. It emits one output period for every N input cycles. N comes from one of two pairs of moduli. A static ratio-select input chooses the short pair (32/33) or the long pair (64/65). A modulus-control input, normally driven by the swallow counter of a frequency synthesizer, chooses the smaller or the larger value of that pair. A high level on modulus control gives the smaller value.

Both control inputs are captured once per period, on the clock edge that closes the period. The captured values set the length of the period that starts on that edge. Changes made between two such edges therefore never stretch or cut the period in progress. Within each period the output spends the first floor(N/2) cycles at its active level and the rest at its idle level. A build-time parameter chooses the polarity, so that the period starts with a rising edge for counters that trigger on positive edges, or with a falling edge for counters that trigger on negative edges.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With `ratio_sel`=1 and `mod_ctl`=1 captured at a period start, that period lasts 32 input cycles between successive active edges.
- R2: With `ratio_sel`=1 and `mod_ctl`=0 captured, the period lasts 33 input cycles.
- R3: With `ratio_sel`=0 and `mod_ctl`=1 captured, the period lasts 64 input cycles.
- R4: With `ratio_sel`=0 and `mod_ctl`=0 captured, the period lasts 65 input cycles.
- R5: Both controls are sampled only on the clock edge where a new period begins, which is also the edge that produces the active output edge. Changes or pulses at any other time, including toggles between two clock edges, have no effect on any period length.
- R6: In a period of N cycles, the output holds its active level for exactly floor(N/2) cycles starting at the period start, and holds its idle level for the remaining cycles.
- R7: With `ACTIVE_RISE`=1 the active level is 1 and the idle level is 0, so each period starts with a rising edge. With `ACTIVE_RISE`=0 the waveform is inverted, so each period starts with a falling edge.
- R8: While `rst`=1 (synchronous, active high) the output sits at its idle level from the next clock edge onward. The first clock edge after `rst` returns to 0 starts a new period: it samples the controls and drives the output to its active level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 1 | Pair select: 1 gives 32/33, 0 gives 64/65 |
| mod_ctl | input | 1 | Modulus control: 1 gives the lower value of the pair, 0 the upper |
| div_out | output | 1 | Registered divided output; polarity set by `ACTIVE_RISE` |

## Verification
The output register is loaded from the next-state count, so a period start shows up at `div_out` on the same clock edge that samples the controls. The bench reads the outputs and the controls 5 ns after each rising edge. At that point the controls still hold the values that edge captured, because the bench changes them only on falling edges or in narrow pulses well clear of any rising edge. A period's length and active-phase width are known only when the next active edge arrives, so each is checked one period later. Each is compared against the value captured at the edge that opened the period. Reset effects are checked at the first falling edge after `rst` is applied, and the restart is checked 5 ns after the first rising edge following its release.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

  // Output phase inside one period
  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_ACTIVE = 1'b1
  } phase_t;

  // Length of the next period from the two control levels.
  // pair_sel = 1 picks the short pair; lower_sel = 1 picks its smaller value.
  function automatic int unsigned next_modulus(
    input int unsigned short_base,
    input int unsigned long_base,
    input logic        pair_sel,
    input logic        lower_sel
  );
    int unsigned base;
    base = pair_sel ? short_base : long_base;
    return lower_sel ? base : base + 1;
  endfunction

endpackage

// File: rtl/dmp_ctl_sampler.sv
module dmp_ctl_sampler #(
  parameter int unsigned SHORT_BASE = 32,
  parameter int unsigned LONG_BASE  = 64,
  parameter int unsigned CW         = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boundary_i,
  input  logic          ratio_i,
  input  logic          mod_i,
  output logic [CW-1:0] len_q_o,
  output logic [CW-1:0] len_d_o
);

  localparam logic [CW-1:0] LEN_A_LO = CW'(SHORT_BASE);
  localparam logic [CW-1:0] LEN_A_HI = CW'(SHORT_BASE + 1);
  localparam logic [CW-1:0] LEN_B_LO = CW'(LONG_BASE);
  localparam logic [CW-1:0] LEN_B_HI = CW'(LONG_BASE + 1);

  logic [CW-1:0] len_q;
  logic [CW-1:0] len_pick;

  always_comb begin
    len_pick = CW'(dmp_pkg::next_modulus(SHORT_BASE, LONG_BASE, ratio_i, mod_i));
    len_d_o  = boundary_i ? len_pick : len_q;
  end

  always_ff @(posedge clk) begin
    if (rst) len_q <= LEN_A_LO;
    else     len_q <= len_d_o;
  end

  assign len_q_o = len_q;

  // R5: the period length only moves on a period boundary
  a_r5_len_held_mid_period: assert property (@(posedge clk) disable iff (rst)
    !boundary_i |=> $stable(len_q));

  // R1 R2 R3 R4: the held length is always one of the four moduli
  a_r4_len_is_legal: assert property (@(posedge clk) disable iff (rst)
    (len_q == LEN_A_LO) || (len_q == LEN_A_HI) ||
    (len_q == LEN_B_LO) || (len_q == LEN_B_HI));

endmodule

// File: rtl/dmp_period_counter.sv
module dmp_period_counter #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] len_q_i,
  output logic [CW-1:0] cnt_d_o,
  output logic          boundary_o
);

  logic [CW-1:0] cnt_q;
  logic          start_q;   // forces a period start on the first edge after reset

  always_comb begin
    boundary_o = start_q || (cnt_q == len_q_i - CW'(1));
    cnt_d_o    = boundary_o ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      start_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d_o;
      start_q <= 1'b0;
    end
  end

  // R1 R2 R3 R4: the position never reaches the held length
  a_r1_cnt_below_len: assert property (@(posedge clk) disable iff (rst)
    cnt_q < len_q_i);

  // R8: the edge right after reset release opens a period
  a_r8_restart_opens_period: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));

endmodule

// File: rtl/dmp_wave_gen.sv
module dmp_wave_gen #(
  parameter int unsigned CW          = 7,
  parameter bit          ACTIVE_RISE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [CW-1:0] cnt_d_i,
  input  logic [CW-1:0] len_d_i,
  output logic          out_o
);

  localparam logic IDLE_LVL = ACTIVE_RISE ? 1'b0 : 1'b1;
  localparam logic ACT_LVL  = ~IDLE_LVL;

  dmp_pkg::phase_t phase_d;
  logic            out_q;

  always_comb begin
    phase_d = (cnt_d_i < (len_d_i >> 1)) ? dmp_pkg::PH_ACTIVE : dmp_pkg::PH_IDLE;
  end

  generate
    if (ACTIVE_RISE) begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= (phase_d == dmp_pkg::PH_ACTIVE);
      end
    end else begin : g_fall
      always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b1;
        else     out_q <= (phase_d != dmp_pkg::PH_ACTIVE);
      end
    end
  endgenerate

  assign out_o = out_q;

  // R8: reset parks the output at idle
  a_r8_idle_in_reset: assert property (@(posedge clk)
    rst |=> (out_q == IDLE_LVL));

  // R7: every period opens at the active level
  a_r7_active_at_start: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (out_q == ACT_LVL));

  // R6: an idle-to-active change happens only on a period start
  a_r6_rise_only_at_start: assert property (@(posedge clk) disable iff (rst)
    (out_q == IDLE_LVL) && !start_i |=> (out_q == IDLE_LVL) || $past(rst));

endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
  parameter int unsigned SHORT_BASE  = 32,
  parameter int unsigned LONG_BASE   = 64,
  parameter bit          ACTIVE_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ratio_sel,
  input  logic mod_ctl,
  output logic div_out
);

  localparam int unsigned CW = $clog2(LONG_BASE + 2);

  logic [CW-1:0] len_q;
  logic [CW-1:0] len_d;
  logic [CW-1:0] cnt_d;
  logic          boundary;

  dmp_ctl_sampler #(
    .SHORT_BASE (SHORT_BASE),
    .LONG_BASE  (LONG_BASE),
    .CW         (CW)
  ) u_sampler (
    .clk        (clk),
    .rst        (rst),
    .boundary_i (boundary),
    .ratio_i    (ratio_sel),
    .mod_i      (mod_ctl),
    .len_q_o    (len_q),
    .len_d_o    (len_d)
  );

  dmp_period_counter #(
    .CW (CW)
  ) u_counter (
    .clk        (clk),
    .rst        (rst),
    .len_q_i    (len_q),
    .cnt_d_o    (cnt_d),
    .boundary_o (boundary)
  );

  dmp_wave_gen #(
    .CW          (CW),
    .ACTIVE_RISE (ACTIVE_RISE)
  ) u_wave (
    .clk     (clk),
    .rst     (rst),
    .start_i (boundary),
    .cnt_d_i (cnt_d),
    .len_d_i (len_d),
    .out_o   (div_out)
  );

  initial begin
    assert (SHORT_BASE >= 4 && LONG_BASE > SHORT_BASE + 1)
      else $error("dual_mod_prescaler: moduli out of range");
  end

endmodule

// File: tb/sim_dual_mod_prescaler.sv
module sim_dual_mod_prescaler;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ratio_sel = 1'b1;
  logic mod_ctl = 1'b1;
  logic div0;
  logic div1;

  always #10 clk = ~clk;   // 50 MHz

  dual_mod_prescaler #(.ACTIVE_RISE(1'b1)) u0 (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .mod_ctl(mod_ctl), .div_out(div0));
  dual_mod_prescaler #(.ACTIVE_RISE(1'b0)) u1 (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .mod_ctl(mod_ctl), .div_out(div1));

  int n_chk = 0;
  int n_bad = 0;
  int n_periods = 0;
  logic prev0 = 1'b0;
  int len_cnt = 0;
  int hi_cnt = 0;
  int exp_n = 0;
  string exp_tag = "R1";
  bit have = 1'b0;

  function automatic int exp_len(logic r, logic m);
    if (r) return m ? 32 : 33;
    return m ? 64 : 65;
  endfunction

  function automatic string tag_of(logic r, logic m);
    if (r && m)  return "R1";
    if (r && !m) return "R2";
    if (!r && m) return "R3";
    return "R4";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Period monitor: 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (rst) begin
      have  = 1'b0;
      prev0 = div0;
    end else begin
      chk(div1 == ~div0, "R7", "inverted variant level", int'(div1), int'(~div0));
      if (div0 && !prev0) begin
        if (have) begin
          chk(len_cnt == exp_n, exp_tag, "period length", len_cnt, exp_n);
          chk(hi_cnt == exp_n / 2, "R6", "active phase width", hi_cnt, exp_n / 2);
          n_periods++;
        end
        // R5: the controls seen at this edge set the new period
        exp_n   = exp_len(ratio_sel, mod_ctl);
        exp_tag = tag_of(ratio_sel, mod_ctl);
        len_cnt = 1;
        hi_cnt  = 1;
        have    = 1'b1;
      end else begin
        len_cnt++;
        if (div0) hi_cnt++;
      end
      prev0 = div0;
    end
  end

  task automatic wait_periods(input int k);
    int start;
    start = n_periods;
    while (n_periods < start + k) @(negedge clk);
  endtask

  // R8: reset parks outputs idle, release restarts at active level
  task automatic do_reset(input int hold);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(div0 == 1'b0, "R8", "rise variant idle in reset", int'(div0), 0);
    chk(div1 == 1'b1, "R8", "fall variant idle in reset", int'(div1), 1);
    repeat (hold) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #5;
    chk(div0 == 1'b1, "R8", "rise variant active after release", int'(div0), 1);
    chk(div1 == 1'b0, "R7", "fall variant active after release", int'(div1), 0);
  endtask

  // R1..R4 directed: hold one setting for several periods
  task automatic run_mode(input logic r, input logic m, input int k);
    int start;
    @(negedge clk);
    ratio_sel = r;
    mod_ctl   = m;
    start = n_periods;
    wait_periods(k + 1);
    chk(n_periods - start >= k + 1, tag_of(r, m), "periods observed", n_periods - start, k + 1);
  endtask

  // R5: narrow pulses between clock edges must not change the length
  task automatic run_glitch(input int cycles);
    int start;
    @(negedge clk);
    ratio_sel = 1'b1;
    mod_ctl   = 1'b1;
    start = n_periods;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      #12 mod_ctl = 1'b0;
      #2  ratio_sel = 1'b0;
      #2  mod_ctl = 1'b1;
      #1  ratio_sel = 1'b1;
    end
    chk(n_periods > start, "R5", "periods during glitches", n_periods - start, 1);
  endtask

  // R5: change controls in mid-period; current period must keep its length
  task automatic run_midchange();
    @(negedge clk);
    ratio_sel = 1'b1;
    mod_ctl   = 1'b1;
    wait_periods(2);
    repeat (10) @(negedge clk);
    ratio_sel = 1'b0;
    mod_ctl   = 1'b0;
    wait_periods(2);
    repeat (20) @(negedge clk);
    mod_ctl = 1'b1;
    wait_periods(2);
  endtask

  // R5: random control traffic, every period checked by the monitor
  task automatic run_random(input int cycles);
    int start;
    start = n_periods;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if ($urandom_range(15) == 0) ratio_sel = ~ratio_sel;
      mod_ctl = 1'($urandom_range(1));
    end
    chk(n_periods > start, "R5", "periods during random traffic", n_periods - start, 1);
  endtask

  initial begin
    repeat (20) begin
      @(posedge clk);
      if (n_periods < 0) break;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset(3);
    run_mode(1'b1, 1'b1, 3);   // R1
    run_mode(1'b1, 1'b0, 3);   // R2
    run_mode(1'b0, 1'b1, 3);   // R3
    run_mode(1'b0, 1'b0, 3);   // R4
    run_midchange();           // R5
    run_glitch(200);           // R5
    repeat (17) @(negedge clk);
    do_reset(2);               // R8 mid-period
    run_random(4000);          // R5
    run_mode(1'b0, 1'b0, 2);
    do_reset(1);
    run_mode(1'b1, 1'b0, 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule